// File: doc/BRIEF.md
# Deferred-Condition Branch Resolver

This block resolves conditional branches for a stack processor whose branches are split across two instructions. A compare instruction does the subtraction in the ALU. The same instruction carries a 3-bit selector that says which condition the next conditional branch will test. At the clock edge that ends the compare, the resolver reduces the chosen condition to one bit and stores it.

A later conditional branch looks only at that stored bit. In the same cycle it picks the next program counter: the branch target when the bit is set, otherwise the current PC plus one. The branch therefore takes a single cycle and needs no delay slot.

An unconditional branch always goes to its target. When no branch is issued, the next PC is simply the current PC plus one. The fetch path and any pipelining of it sit outside this block.

Top module: `defer_branch`

## Requirements
- R1: While reset is held, and after reset until the first compare, the stored condition bit is 0, so a conditional branch issued in that window is not taken.
- R2: When `cmp_en` is high at a rising edge, the stored bit takes the condition named by `cond_sel`. The codes are: 0 result equals zero; 1 result is not zero; 2 result is negative (MSB of `alu_res` set); 3 `alu_carry`; 4 `alu_ovf`; 5 constant 1; 6 and 7 constant 0.
- R3: In any cycle with `cmp_en` low, the stored bit keeps its value, whatever the ALU result and flags do.
- R4: With `br_cond` high and the stored bit 1, `taken` is 1 and `next_pc` equals `br_target` in that same cycle.
- R5: With `br_cond` high and the stored bit 0, `taken` is 0 and `next_pc` is `pc`+1, wrapping from all ones to zero.
- R6: With `br_uncond` high, `taken` is 1 and `next_pc` equals `br_target`, whatever the stored bit and `br_cond` are.
- R7: With no branch strobe, `taken` is 0 and `next_pc` is `pc`+1.
- R8: When a compare and a conditional branch fall in the same cycle, the branch uses the bit stored before that compare. The new bit only applies to branches in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | PC_W | Address of the current instruction |
| alu_res | input | DATA_W | ALU subtraction result |
| alu_carry | input | 1 | ALU carry flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| cmp_en | input | 1 | Decoded compare strobe |
| cond_sel | input | 3 | Condition selector carried by the compare |
| br_cond | input | 1 | Decoded conditional-branch strobe |
| br_uncond | input | 1 | Decoded unconditional-branch strobe |
| br_target | input | PC_W | Branch destination |
| next_pc | output | PC_W | Address of the next instruction |
| taken | output | 1 | Branch is taken this cycle |
| cond_flag | output | 1 | Stored condition bit |

## Verification
Two functions can fall in the same cycle: a compare that writes the stored bit, and a conditional branch that reads it. The bench provokes this in two ways. Directed steps issue a compare and a branch together, with selectors that flip the bit (for example code 5 after code 6). Long random runs drive both strobes independently as well. A behavioural reference model updates its bit only after the edge, so the branch decision is judged against the previous value and the new value is judged on the following branch.

// File: rtl/defer_branch.sv
module defer_branch #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              cmp_en,
  input  logic [2:0]        cond_sel,
  input  logic              br_cond,
  input  logic              br_uncond,
  input  logic [PC_W-1:0]   br_target,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              cond_flag
);

  logic res_zero, res_neg, picked;

  assign res_zero = (alu_res == '0);
  assign res_neg  = alu_res[DATA_W-1];

  always_comb begin
    case (cond_sel)
      3'd0:    picked = res_zero;
      3'd1:    picked = !res_zero;
      3'd2:    picked = res_neg;
      3'd3:    picked = alu_carry;
      3'd4:    picked = alu_ovf;
      3'd5:    picked = 1'b1;
      default: picked = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cond_flag <= 1'b0;
    else if (cmp_en) cond_flag <= picked;
  end

  assign taken   = br_uncond | (br_cond & cond_flag);
  assign next_pc = taken ? br_target : pc + 1'b1;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(cond_flag));

  p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cond_sel == 3'd5) |=> cond_flag);

  p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cond_sel[2:1] == 2'b11) |=> !cond_flag);

  p_uncond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_uncond |-> (taken && next_pc == br_target));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_uncond && !br_cond) |-> (!taken && next_pc == pc + 1'b1));

  p_old_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond && !br_uncond && !$past(cmp_en)) |-> (taken == $past(cond_flag)));

endmodule

// File: tb/sim_defer_branch.sv
`timescale 1ns/1ps
module sim_defer_branch;
  localparam int PC_W = 16;
  localparam int DATA_W = 16;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pc = '0, br_target = '0;
  logic [DATA_W-1:0] alu_res = '0;
  logic alu_carry = 0, alu_ovf = 0, cmp_en = 0, br_cond = 0, br_uncond = 0;
  logic [2:0] cond_sel = '0;
  logic [PC_W-1:0] next_pc;
  logic taken, cond_flag;

  int checks = 0, fails = 0;
  bit model_flag = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  defer_branch #(.PC_W(PC_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pc(pc), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .cmp_en(cmp_en), .cond_sel(cond_sel), .br_cond(br_cond),
    .br_uncond(br_uncond), .br_target(br_target), .next_pc(next_pc),
    .taken(taken), .cond_flag(cond_flag));

  function automatic bit cond_of(input logic [2:0] s, input logic [DATA_W-1:0] r,
                                 input logic c, input logic v);
    case (s)
      0: return r == 0;
      1: return r != 0;
      2: return r[DATA_W-1];
      3: return c;
      4: return v;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit c_en, input logic [2:0] s, input logic [DATA_W-1:0] r,
                      input bit c, input bit v, input bit bc, input bit bu,
                      input logic [PC_W-1:0] p, input logic [PC_W-1:0] t);
    string tag;
    bit exp_taken;
    logic [PC_W-1:0] exp_pc;
    @(negedge clk);
    cmp_en = c_en; cond_sel = s; alu_res = r; alu_carry = c; alu_ovf = v;
    br_cond = bc; br_uncond = bu; pc = p; br_target = t;
    #1;
    exp_taken = bu || (bc && model_flag);
    exp_pc = exp_taken ? t : PC_W'(p + 1);
    if (bu) tag = "R6";
    else if (bc && c_en) tag = "R8";
    else if (bc) tag = model_flag ? "R4" : "R5";
    else tag = "R7";
    check(tag, taken, exp_taken);
    check(tag, next_pc, exp_pc);
    check("R2 or R3 stored bit", cond_flag, model_flag);
    @(posedge clk);
    if (c_en) model_flag = cond_of(s, r, c, v);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    br_cond = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 flag in reset", cond_flag, 0);
    check("R1 no take in reset", taken, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 1, 0, 16'h0010, 16'h0400);  // R1 after reset: not taken
    // R2: every selector, then branch on the stored bit (R4 / R5)
    for (int s = 0; s < 8; s++) begin
      step(1, 3'(s), 16'h0000, 1, 0, 0, 0, 16'h0100, 16'h0);
      step(0, 0, 16'h1234, 0, 1, 1, 0, 16'h0101, 16'h0A00);
      step(1, 3'(s), 16'h8001, 0, 1, 0, 0, 16'h0102, 16'h0);
      step(0, 0, 16'h0000, 1, 0, 1, 0, 16'h0103, 16'h0B00);
      step(1, 3'(s), 16'h0005, 1, 1, 0, 0, 16'h0104, 16'h0);
      step(0, 0, 16'h0000, 0, 0, 1, 0, 16'h0105, 16'h0C00);
    end
    // R3: bit set, then many non-compare cycles with moving flags
    step(1, 5, 0, 0, 0, 0, 0, 16'h0200, 0);
    for (int i = 0; i < 6; i++)
      step(0, 3'(i), 16'(i * 7), i[0], i[1], 0, 0, 16'(16'h0201 + i), 0);
    step(0, 0, 0, 0, 0, 1, 0, 16'h0210, 16'h0E00);     // R3 still taken
    // R8: compare and branch together, bit flips both ways
    step(1, 6, 0, 0, 0, 1, 0, 16'h0300, 16'h0F00);     // uses old 1
    step(0, 0, 0, 0, 0, 1, 0, 16'h0301, 16'h0F00);     // new 0
    step(1, 5, 0, 0, 0, 1, 0, 16'h0302, 16'h0F10);     // uses old 0
    step(0, 0, 0, 0, 0, 1, 0, 16'h0303, 16'h0F20);     // new 1
    // R6: unconditional with bit 1 then 0
    step(0, 0, 0, 0, 0, 0, 1, 16'h0400, 16'h1000);
    step(1, 7, 0, 0, 0, 0, 0, 16'h0401, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0402, 16'h1100);
    step(0, 0, 0, 0, 0, 1, 1, 16'h0403, 16'h1200);
    // R5: wrap of PC+1 on a not-taken branch, R7 wrap with no branch
    step(0, 0, 0, 0, 0, 1, 0, 16'hFFFF, 16'h1300);
    step(0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 16'h1300);
    // random mix of all functions
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 2) == 0, 3'($urandom), 16'($urandom_range(0, 3) == 0 ? 0 : $urandom),
           1'($urandom), 1'($urandom), $urandom_range(0, 2) == 0, $urandom_range(0, 6) == 0,
           16'($urandom), 16'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule